// File: doc/BRIEF.md
# Synthesizer Test Mode and Reference Divider Control

This block is the digital control for a frequency synthesizer. It turns a three-bit test code into two things:

- the drive for the charge pump, and
- the choice of signal shown on the lock pin.

It also divides a crystal-derived clock by one of three programmable ratios to make the comparison reference for the phase detector.

In normal operation the charge pump follows the up/down pulses of the phase detector, and the lock pin shows the lock detector. Test codes can turn the pump off, or force it to sink or source current continuously. Other codes route internal frequencies onto the lock pin so they can be measured on a tester: either the divided reference, or half the rate of the programmable (VCO) divider output. Two ratio-select bits pick the reference ratio. The default ratios are 512, 640 and 1024. A new ratio takes effect only at the end of the period in progress.

All logic runs on the crystal-derived clock. The divided VCO signal is sampled in that clock domain, and its rising edges are detected there.

Top module: `synth_test_ctrl`

## Requirements
- R1: Test codes 3'b000 and 3'b001 give tracking mode.
  - `pump_up` equals `pd_up & ~pd_dn`.
  - `pump_dn` equals `pd_dn & ~pd_up`.
  - `lock_out` equals `lock_det`.
- R2: Test codes 3'b010 and 3'b011 hold both `pump_up` and `pump_dn` low whatever the phase detector does. `lock_out` equals `lock_det`.
- R3: Code 3'b110 holds `pump_dn`=1 and `pump_up`=0. Code 3'b111 holds `pump_up`=1 and `pump_dn`=0. In both codes `lock_out` equals `lock_det`.
- R4: Code 3'b100 drives `lock_out` with `ref_out`, and the pump tracks the phase detector as in R1.
- R5: Code 3'b101 drives `lock_out` with a half-rate signal.
  - The half-rate signal is 0 after reset.
  - It inverts once in the clock cycle after each rising edge of `div_in`, and holds at all other times.
  - It counts `div_in` edges in every test code, not only in 3'b101.
- R6: The ratio is chosen from `{rs_b, rs_a}` as follows:
  - `rs_b`=0 selects RATIO_MID (default 640), whatever `rs_a` is.
  - `rs_b`=1 with `rs_a`=1 selects RATIO_HI (default 1024).
  - `rs_b`=1 with `rs_a`=0 selects RATIO_LO (default 512).
- R7: Each reference period lasts exactly the selected ratio in clock cycles. `ref_out` is high for the first ratio/2 cycles of the period and low for the rest. The first period after reset uses RATIO_MID.
- R8: A ratio change applied partway through a period does not alter that period. The new ratio governs the next period.
- R9: `pump_up` and `pump_dn` are never high together.
- R10: While reset is asserted, `ref_out` is 1 and the half-rate signal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_code | input | 3 | Test mode code |
| rs_a | input | 1 | Ratio select, low bit |
| rs_b | input | 1 | Ratio select, high bit |
| pd_up | input | 1 | Phase detector up pulse |
| pd_dn | input | 1 | Phase detector down pulse |
| lock_det | input | 1 | Lock detector state |
| div_in | input | 1 | Programmable divider output, sampled in clk domain |
| pump_up | output | 1 | Charge pump source enable |
| pump_dn | output | 1 | Charge pump sink enable |
| ref_out | output | 1 | Divided reference, square wave |
| lock_out | output | 1 | Lock pin output |

## Verification
The half-rate assertions assume that `div_in` is synchronous to `clk` and stays at each level for at least one full clock cycle. The stimulus therefore changes `div_in` only on falling clock edges and holds each level for two cycles.

The divider assertions assume the ratio parameters are even and at least four; the bench overrides them with small values (8, 10, 16) to meet this. Ratio selects may change at any cycle. The bench changes them both between periods and partway through a period, so that the deferred-load rule is exercised.

// File: rtl/synth_test_pkg.sv
package synth_test_pkg;
   typedef enum logic [1:0] {
      PUMP_TRACK  = 2'd0,
      PUMP_IDLE   = 2'd1,
      PUMP_SINK   = 2'd2,
      PUMP_SOURCE = 2'd3
   } pump_mode_e;

   typedef enum logic [1:0] {
      LOCK_FROM_DET  = 2'd0,
      LOCK_FROM_REF  = 2'd1,
      LOCK_FROM_HALF = 2'd2
   } lock_src_e;

   typedef enum logic [1:0] {
      RSEL_LO  = 2'd0,
      RSEL_MID = 2'd1,
      RSEL_HI  = 2'd2
   } ratio_sel_e;
endpackage

// File: rtl/stc_mode_decode.sv
module stc_mode_decode
   import synth_test_pkg::*;
(
   input  logic [2:0] test_code,
   output pump_mode_e pump_mode,
   output lock_src_e  lock_src
);
   always_comb begin
      pump_mode = PUMP_TRACK;
      lock_src  = LOCK_FROM_DET;
      case (test_code)
         3'b010, 3'b011: pump_mode = PUMP_IDLE;
         3'b110:         pump_mode = PUMP_SINK;
         3'b111:         pump_mode = PUMP_SOURCE;
         3'b100:         lock_src  = LOCK_FROM_REF;
         3'b101:         lock_src  = LOCK_FROM_HALF;
         default: begin
            pump_mode = PUMP_TRACK;
            lock_src  = LOCK_FROM_DET;
         end
      endcase
   end
endmodule

// File: rtl/stc_pump_gate.sv
module stc_pump_gate
   import synth_test_pkg::*;
(
   input  pump_mode_e pump_mode,
   input  logic       pd_up,
   input  logic       pd_dn,
   output logic       pump_up,
   output logic       pump_dn
);
   always_comb begin
      pump_up = 1'b0;
      pump_dn = 1'b0;
      case (pump_mode)
         PUMP_TRACK: begin
            // simultaneous pulses cancel so the enables stay exclusive
            pump_up = pd_up & ~pd_dn;
            pump_dn = pd_dn & ~pd_up;
         end
         PUMP_SINK:   pump_dn = 1'b1;
         PUMP_SOURCE: pump_up = 1'b1;
         default: begin
            pump_up = 1'b0;
            pump_dn = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/stc_ref_divider.sv
module stc_ref_divider
   import synth_test_pkg::*;
#(
   parameter int RATIO_LO  = 512,
   parameter int RATIO_MID = 640,
   parameter int RATIO_HI  = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rs_a,
   input  logic rs_b,
   output logic ref_out
);
   localparam int RMAX_LM = (RATIO_LO > RATIO_MID) ? RATIO_LO : RATIO_MID;
   localparam int RMAX    = (RMAX_LM > RATIO_HI) ? RMAX_LM : RATIO_HI;
   localparam int RW      = $clog2(RMAX + 1);

   if ((RATIO_LO % 2) != 0 || (RATIO_MID % 2) != 0 || (RATIO_HI % 2) != 0) begin : g_odd_ratio
      $error("stc_ref_divider: every ratio must be even");
   end
   if (RATIO_LO < 4 || RATIO_MID < 4 || RATIO_HI < 4) begin : g_small_ratio
      $error("stc_ref_divider: every ratio must be at least 4");
   end

   ratio_sel_e      sel;
   logic [RW-1:0]   ratio_sel_val;
   logic [RW-1:0]   ratio_q;
   logic [RW-1:0]   cnt;
   logic [RW-1:0]   cnt_inc;
   logic [RW-1:0]   half_len;
   logic            term;
   logic            ref_q;

   always_comb begin
      case ({rs_b, rs_a})
         2'b11:   sel = RSEL_HI;
         2'b10:   sel = RSEL_LO;
         default: sel = RSEL_MID;
      endcase
   end

   always_comb begin
      case (sel)
         RSEL_LO: ratio_sel_val = RW'(RATIO_LO);
         RSEL_HI: ratio_sel_val = RW'(RATIO_HI);
         default: ratio_sel_val = RW'(RATIO_MID);
      endcase
   end

   assign cnt_inc  = cnt + RW'(1);
   assign half_len = ratio_q >> 1;
   assign term     = (cnt_inc == ratio_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= RW'(RATIO_MID);
         ref_q   <= 1'b1;
      end else if (term) begin
         cnt     <= '0;
         ratio_q <= ratio_sel_val;
         ref_q   <= 1'b1;
      end else begin
         cnt     <= cnt_inc;
         ref_q   <= (cnt_inc < half_len);
      end
   end

   assign ref_out = ref_q;

   // R7
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratio_q);
   // R7
   ref_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q == (cnt < half_len));
   // R8
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term |=> $stable(ratio_q));
endmodule

// File: rtl/stc_half_rate.sv
module stc_half_rate (
   input  logic clk,
   input  logic rst_n,
   input  logic div_in,
   output logic half_out
);
   logic div_q;
   logic half_q;
   logic div_rise;

   assign div_rise = div_in & ~div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= 1'b0;
         half_q <= 1'b0;
      end else begin
         div_q <= div_in;
         if (div_rise) half_q <= ~half_q;
      end
   end

   assign half_out = half_q;

   // R5
   half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_rise |=> (half_q != $past(half_q)));
   // R5
   half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_rise |=> $stable(half_q));
endmodule

// File: rtl/synth_test_ctrl.sv
module synth_test_ctrl
   import synth_test_pkg::*;
#(
   parameter int RATIO_LO  = 512,
   parameter int RATIO_MID = 640,
   parameter int RATIO_HI  = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] test_code,
   input  logic       rs_a,
   input  logic       rs_b,
   input  logic       pd_up,
   input  logic       pd_dn,
   input  logic       lock_det,
   input  logic       div_in,
   output logic       pump_up,
   output logic       pump_dn,
   output logic       ref_out,
   output logic       lock_out
);
   if (RATIO_LO == RATIO_MID || RATIO_LO == RATIO_HI || RATIO_MID == RATIO_HI) begin : g_dup_ratio
      $error("synth_test_ctrl: the three ratios must differ");
   end

   pump_mode_e pump_mode;
   lock_src_e  lock_src;
   logic       half_sig;

   stc_mode_decode i_decode (
      .test_code (test_code),
      .pump_mode (pump_mode),
      .lock_src  (lock_src)
   );

   stc_pump_gate i_pump (
      .pump_mode (pump_mode),
      .pd_up     (pd_up),
      .pd_dn     (pd_dn),
      .pump_up   (pump_up),
      .pump_dn   (pump_dn)
   );

   stc_ref_divider #(
      .RATIO_LO  (RATIO_LO),
      .RATIO_MID (RATIO_MID),
      .RATIO_HI  (RATIO_HI)
   ) i_refdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .rs_a    (rs_a),
      .rs_b    (rs_b),
      .ref_out (ref_out)
   );

   stc_half_rate i_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_in   (div_in),
      .half_out (half_sig)
   );

   always_comb begin
      case (lock_src)
         LOCK_FROM_REF:  lock_out = ref_out;
         LOCK_FROM_HALF: lock_out = half_sig;
         default:        lock_out = lock_det;
      endcase
   end

   // R9
   pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pump_up, pump_dn}));
   // R3
   pump_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code == 3'b110) |-> (pump_dn && !pump_up));
   // R3
   pump_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code == 3'b111) |-> (pump_up && !pump_dn));
   // R2
   pump_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code[2:1] == 2'b01) |-> (!pump_up && !pump_dn));
   // R4
   lock_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code == 3'b100) |-> (lock_out == ref_out));
endmodule

// File: tb/test_synth_test_ctrl.sv
module test_synth_test_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int R_LO  = 8;
   localparam int R_MID = 10;
   localparam int R_HI  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] test_code = 3'b101;
   logic       rs_a = 1'b0, rs_b = 1'b0;
   logic       pd_up = 1'b0, pd_dn = 1'b0, lock_det = 1'b0, div_in = 1'b0;
   logic       pump_up, pump_dn, ref_out, lock_out;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   logic exp_half = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   synth_test_ctrl #(.RATIO_LO(R_LO), .RATIO_MID(R_MID), .RATIO_HI(R_HI)) i_synth_test_ctrl (
      .clk(clk), .rst_n(rst_n), .test_code(test_code), .rs_a(rs_a), .rs_b(rs_b),
      .pd_up(pd_up), .pd_dn(pd_dn), .lock_det(lock_det), .div_in(div_in),
      .pump_up(pump_up), .pump_dn(pump_dn), .ref_out(ref_out), .lock_out(lock_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_rise();
      logic p;
      p = ref_out;
      forever begin
         @(negedge clk);
         if (!p && ref_out) break;
         p = ref_out;
      end
   endtask

   // called on the sample where ref_out has just risen; counts one period
   task automatic period_len(input int chg_at, input logic na, input logic nb,
                             output int n, output int h);
      logic p;
      n = 0; h = 0;
      forever begin
         if (ref_out) h++;
         n++;
         p = ref_out;
         if (n == chg_at) begin rs_a = na; rs_b = nb; end
         @(negedge clk);
         if (!p && ref_out) break;
      end
   endtask

   function automatic int ratio_of(input logic a, input logic b);
      if (!b) return R_MID;
      return a ? R_HI : R_LO;
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int n, h;
      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 ref_out in reset", ref_out, 1);
      chk("R10 half-rate in reset", lock_out, 0);
      rst_n = 1'b1;

      // R7 first period after reset uses the middle ratio
      wait_rise();
      period_len(0, 1'b0, 1'b0, n, h);
      chk("R7 first period", n, R_MID);

      // R1 R2 R3 R4 R9 sweep over codes and detector inputs
      for (int c = 0; c < 8; c++) begin
         for (int pd = 0; pd < 4; pd++) begin
            for (int ld = 0; ld < 2; ld++) begin
               logic eu, ed, el;
               string tag;
               @(negedge clk);
               test_code = 3'(c);
               pd_up = pd[0]; pd_dn = pd[1]; lock_det = ld[0];
               #1;
               eu = pd_up & ~pd_dn; ed = pd_dn & ~pd_up; el = lock_det; tag = "R1";
               case (c)
                  2, 3: begin eu = 0; ed = 0; tag = "R2"; end
                  6:    begin eu = 0; ed = 1; tag = "R3"; end
                  7:    begin eu = 1; ed = 0; tag = "R3"; end
                  4:    begin el = ref_out; tag = "R4"; end
                  5:    begin el = exp_half; tag = "R5"; end
                  default: ;
               endcase
               chk({tag, " pump_up"}, pump_up, eu);
               chk({tag, " pump_dn"}, pump_dn, ed);
               chk({tag, " lock_out"}, lock_out, el);
               chk("R9 exclusive", int'(pump_up & pump_dn), 0);
            end
         end
      end

      // R4 lock pin follows reference over a full period
      @(negedge clk);
      test_code = 3'b100;
      for (int i = 0; i < 2 * R_MID; i++) begin
         @(negedge clk);
         chk("R4 lock_out=ref_out", lock_out, ref_out);
      end

      // R5 half-rate toggling, including edges seen under another code
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         test_code = (k == 5) ? 3'b001 : 3'b101;
         div_in = 1'b1;
         exp_half = ~exp_half;
         @(negedge clk);
         test_code = 3'b101;
         #1;
         chk("R5 toggle", lock_out, exp_half);
         @(negedge clk);
         div_in = 1'b0;
         @(negedge clk);
         chk("R5 hold", lock_out, exp_half);
      end

      // R6 R7 each select combination
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         rs_a = s[0]; rs_b = s[1];
         wait_rise();
         wait_rise();
         period_len(0, 1'b0, 1'b0, n, h);
         chk("R6 period", n, ratio_of(s[0], s[1]));
         chk("R7 high time", h, ratio_of(s[0], s[1]) / 2);
      end

      // R8 change mid-period: current period keeps the old length
      @(negedge clk);
      rs_a = 1'b0; rs_b = 1'b0;
      wait_rise(); wait_rise();
      period_len(3, 1'b1, 1'b1, n, h);
      chk("R8 period in progress", n, R_MID);
      period_len(0, 1'b1, 1'b1, n, h);
      chk("R8 next period", n, R_HI);
      period_len(5, 1'b0, 1'b1, n, h);
      chk("R8 period in progress 2", n, R_HI);
      period_len(0, 1'b0, 1'b1, n, h);
      chk("R8 next period 2", n, R_LO);
      chk("R7 high time lo", h, R_LO / 2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule